// File: doc/BRIEF.md
# Memory-module presence-data timing decoder

This block receives the configuration image of a synchronous DRAM module one byte per cycle, as a byte index with its value. The bytes come from the module's small configuration memory. The block keeps the first copy of each of the 64 base bytes. It adds up bytes 0 to 62 and compares the low eight bits of that sum with the stored checksum in byte 63. From the kept bytes it derives the memory type, the row, column and bank address widths, and which CAS latencies the controller can use at its own clock period.

It also converts the four row-timing parameters into whole controller clocks, rounding up. The parameters are precharge time, activate-to-activate delay, activate-to-column delay and minimum active time, and each is stored as a byte in whole nanoseconds. The division runs by repeated subtraction in a small sequencer. A memory controller loads this block at boot, sets its clock period in tenths of a nanosecond, and waits for the valid flag or the checksum-error flag before it programs its own timers. A one-cycle start pulse clears the block for a new image.

Top module: `spd_timing_decoder`

## Requirements
- R1: After reset, infoValid and csumErr are 0, and all four timing counts, casUsable, rowBits, colBits, bankBits and isSdram are 0.
- R2: A byte whose index is below 64 is stored on its first arrival after reset or after imageStart. A later byte with the same index is ignored until the next imageStart. rowBits shows stored byte 3, colBits shows byte 4, and isSdram is 1 exactly when byte 2 equals 04h. bankBits is log2 of byte 17 when byte 17 is a power of two, and 0 otherwise. These fields update one cycle after the byte is accepted.
- R3: A byte whose index is 64 or above changes no stored state, no flag and no output.
- R4: Once all 64 indices have been stored, csumErr goes to 1 and infoValid stays 0 if byte 63 differs from the low 8 bits of the sum of bytes 0 to 62.
- R5: infoValid rises only after all 64 indices have been stored, the checksum has matched and all four conversions have finished. It then stays at 1 until imageStart.
- R6: Each timing count equals ceiling(ns × 10 / clkPeriodTenths), where ns is the stored byte. tRpClk comes from byte 27, tRrdClk from byte 28, tRcdClk from byte 29 and tRasClk from byte 30. A value of 0 ns gives 0.
- R7: casUsable bit n stands for CAS latency n+1. It can be 1 only if bit n of byte 18 is set. A cycle-time byte encodes whole nanoseconds in its upper nibble and tenths in its lower nibble. The highest set latency uses the cycle time in byte 9, the second highest uses byte 23 and the third uses byte 25. A latency is usable when its cycle time is nonzero and no larger than clkPeriodTenths.
- R8: The decoded results do not depend on the order in which the 64 bytes arrive.
- R9: imageStart clears the stored bytes, both flags and all four timing counts, and the cleared values show one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| imageStart | input | 1 | One-cycle pulse that clears the block for a new image |
| byteValid | input | 1 | byteIdx and byteData hold a byte this cycle |
| byteIdx | input | 8 | Index of the incoming byte |
| byteData | input | 8 | Value of the incoming byte |
| clkPeriodTenths | input | 8 | Controller clock period in tenths of a nanosecond |
| infoValid | output | 1 | Image complete, checksum good, conversions done |
| csumErr | output | 1 | Image complete and checksum mismatch |
| isSdram | output | 1 | Memory type byte identifies synchronous DRAM |
| casUsable | output | 8 | Bit n: CAS latency n+1 is usable at this clock |
| rowBits | output | 8 | Row address width |
| colBits | output | 8 | Column address width |
| bankBits | output | 3 | Bank address width |
| tRpClk | output | 12 | Precharge time in clocks |
| tRcdClk | output | 12 | Activate-to-column delay in clocks |
| tRasClk | output | 12 | Minimum active time in clocks |
| tRrdClk | output | 12 | Activate-to-activate delay in clocks |

## Verification
The bench applies a well-formed image in ascending index order at a 10 ns period, where every timing divides exactly. It then sends the same image in descending order at 7.5 ns, so that every count must round up and both CAS latencies drop out, which separates a floor divider from a ceiling one and shows order independence. A variant with a slower second-latency cycle time leaves exactly one latency usable, which shows that the cycle-time bytes are paired with the correct latency ranks. Further runs repeat an index with a different value, insert out-of-range indices while one byte is still missing, and corrupt a single data byte. These show that the first copy wins, that out-of-range bytes neither complete nor disturb the image, and that a bad sum raises the error flag in place of the valid flag.

// File: rtl/spd_pkg.sv
package spd_pkg;
  localparam int DATA_W       = 8;
  localparam int IDX_MEMTYPE  = 2;
  localparam int IDX_ROWS     = 3;
  localparam int IDX_COLS     = 4;
  localparam int IDX_TCK_HI   = 9;
  localparam int IDX_BANKS    = 17;
  localparam int IDX_CASMAP   = 18;
  localparam int IDX_TCK_MID  = 23;
  localparam int IDX_TCK_LO   = 25;
  localparam int IDX_TIMING0  = 27;
  localparam int IDX_CHECKSUM = 63;
  localparam int NUM_TIMINGS  = 4;
  localparam logic [DATA_W-1:0] MEMTYPE_SDRAM = 8'h04;

  typedef struct packed {
    logic       clearAll;
    logic       loadDiv;
    logic       stepDiv;
    logic [1:0] divSel;
  } dp_strobe_t;

  typedef enum logic [2:0] {
    ST_COLLECT,
    ST_LOAD,
    ST_STEP,
    ST_DONE,
    ST_BAD
  } ctl_state_t;

  function automatic logic [DATA_W-1:0] nibbleTenths(input logic [DATA_W-1:0] b);
    return ({4'b0, b[7:4]} * 8'd10) + {4'b0, b[3:0]};
  endfunction
endpackage

// File: rtl/spd_datapath.sv
module spd_datapath
  import spd_pkg::*;
#(
  parameter int IMG_BYTES = 64,
  parameter int IDX_IN_W  = 8,
  parameter int PER_W     = 8,
  parameter int CNT_W     = 12
) (
  input  logic                                  clk,
  input  logic                                  rstN,
  input  dp_strobe_t                            strobes,
  input  logic                                  byteValid,
  input  logic [IDX_IN_W-1:0]                   byteIdx,
  input  logic [DATA_W-1:0]                     byteData,
  input  logic [PER_W-1:0]                      clkPeriodTenths,
  output logic                                  allSeen,
  output logic                                  sumMatch,
  output logic                                  divFinished,
  output logic                                  isSdram,
  output logic [7:0]                            casUsable,
  output logic [DATA_W-1:0]                     rowBits,
  output logic [DATA_W-1:0]                     colBits,
  output logic [2:0]                            bankBits,
  output logic [NUM_TIMINGS-1:0][CNT_W-1:0]     timingClk
);
  localparam int IDX_W = $clog2(IMG_BYTES);
  localparam int REM_W = DATA_W + 4;

  logic [DATA_W-1:0]    imgMem [IMG_BYTES];
  logic [IMG_BYTES-1:0] seenMask;
  logic [DATA_W-1:0]    runSum;
  logic [IDX_W-1:0]     slot;
  logic                 inRange;
  logic                 acceptByte;
  logic [REM_W-1:0]     remT;
  logic [CNT_W-1:0]     cnt;
  logic [REM_W-1:0]     periodEff;
  logic [DATA_W-1:0]    periodByte;
  logic [DATA_W-1:0]    selNs;

  assign slot       = byteIdx[IDX_W-1:0];
  assign inRange    = (byteIdx < IDX_IN_W'(IMG_BYTES));
  assign acceptByte = byteValid && inRange && !seenMask[slot] && !strobes.clearAll;

  always_ff @(posedge clk) begin
    if (!rstN || strobes.clearAll) begin
      seenMask <= '0;
      runSum   <= '0;
      for (int i = 0; i < IMG_BYTES; i++) imgMem[i] <= '0;
    end else if (acceptByte) begin
      imgMem[slot]   <= byteData;
      seenMask[slot] <= 1'b1;
      if (slot != IDX_W'(IDX_CHECKSUM)) runSum <= runSum + byteData;
    end
  end

  assign allSeen  = &seenMask;
  assign sumMatch = (runSum == imgMem[IDX_CHECKSUM]);

  // Static field decode
  assign isSdram = (imgMem[IDX_MEMTYPE] == MEMTYPE_SDRAM);
  assign rowBits = imgMem[IDX_ROWS];
  assign colBits = imgMem[IDX_COLS];

  always_comb begin
    bankBits = '0;
    for (int i = 0; i < 8; i++)
      if (imgMem[IDX_BANKS] == (DATA_W'(1) << i)) bankBits = 3'(i);
  end

  // Clock period, with zero clamped to one tenth
  assign periodEff  = (clkPeriodTenths == '0) ? REM_W'(1) : REM_W'(clkPeriodTenths);
  assign periodByte = (clkPeriodTenths == '0) ? DATA_W'(1) : DATA_W'(clkPeriodTenths);

  always_comb begin
    int rank;
    logic [DATA_W-1:0] cyc;
    casUsable = '0;
    rank = 0;
    for (int b = 7; b >= 0; b--) begin
      if (imgMem[IDX_CASMAP][b]) begin
        case (rank)
          0:       cyc = imgMem[IDX_TCK_HI];
          1:       cyc = imgMem[IDX_TCK_MID];
          2:       cyc = imgMem[IDX_TCK_LO];
          default: cyc = '0;
        endcase
        if (cyc != '0 && nibbleTenths(cyc) <= periodByte) casUsable[b] = 1'b1;
        rank = rank + 1;
      end
    end
  end

  // Serial divider: repeated subtraction, ceiling result
  assign selNs       = imgMem[IDX_TIMING0 + int'(strobes.divSel)];
  assign divFinished = strobes.stepDiv && (remT <= periodEff);

  always_ff @(posedge clk) begin
    if (!rstN || strobes.clearAll) begin
      remT      <= '0;
      cnt       <= '0;
      timingClk <= '0;
    end else if (strobes.loadDiv) begin
      remT <= REM_W'(selNs) * REM_W'(10);
      cnt  <= '0;
    end else if (strobes.stepDiv) begin
      if (remT <= periodEff) begin
        timingClk[strobes.divSel] <= cnt + CNT_W'(remT != '0);
      end else begin
        remT <= remT - periodEff;
        cnt  <= cnt + CNT_W'(1);
      end
    end
  end

  assert_seen_monotonic_R2: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.clearAll |=> ((seenMask & $past(seenMask)) == $past(seenMask)));

  assert_high_index_ignored_R3: assert property (@(posedge clk) disable iff (!rstN)
    (byteValid && !inRange && !strobes.clearAll) |=> (seenMask == $past(seenMask)));

  assert_rem_shrinks_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.stepDiv && !divFinished && !strobes.clearAll) |=> (remT < $past(remT)));
endmodule

// File: rtl/spd_control.sv
module spd_control
  import spd_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       imageStart,
  input  logic       allSeen,
  input  logic       sumMatch,
  input  logic       divFinished,
  output dp_strobe_t strobes,
  output logic       infoValid,
  output logic       csumErr
);
  ctl_state_t state, stateNext;
  logic [1:0] sel;

  always_comb begin
    strobes          = '0;
    strobes.clearAll = imageStart;
    strobes.divSel   = sel;
    strobes.loadDiv  = (state == ST_LOAD) && !imageStart;
    strobes.stepDiv  = (state == ST_STEP) && !imageStart;
  end

  always_comb begin
    stateNext = state;
    if (imageStart) begin
      stateNext = ST_COLLECT;
    end else begin
      case (state)
        ST_COLLECT: if (allSeen) stateNext = sumMatch ? ST_LOAD : ST_BAD;
        ST_LOAD:    stateNext = ST_STEP;
        ST_STEP:    if (divFinished) stateNext = (sel == 2'(NUM_TIMINGS - 1)) ? ST_DONE : ST_LOAD;
        default:    stateNext = state;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_COLLECT;
      sel   <= '0;
    end else begin
      state <= stateNext;
      if (imageStart || state == ST_COLLECT) sel <= '0;
      else if (state == ST_STEP && divFinished) sel <= sel + 2'd1;
    end
  end

  assign infoValid = (state == ST_DONE);
  assign csumErr   = (state == ST_BAD);

  assert_err_after_full_image_R4: assert property (@(posedge clk) disable iff (!rstN)
    csumErr |-> (allSeen && !sumMatch));

  assert_valid_needs_good_image_R5: assert property (@(posedge clk) disable iff (!rstN)
    infoValid |-> (allSeen && sumMatch));

  assert_valid_holds_R5: assert property (@(posedge clk) disable iff (!rstN)
    (infoValid && !imageStart) |=> infoValid);

  assert_clear_drops_flags_R9: assert property (@(posedge clk) disable iff (!rstN)
    imageStart |=> (!infoValid && !csumErr));
endmodule

// File: rtl/spd_timing_decoder.sv
module spd_timing_decoder
  import spd_pkg::*;
#(
  parameter int IMG_BYTES = 64,
  parameter int IDX_IN_W  = 8,
  parameter int PER_W     = 8,
  parameter int CNT_W     = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               imageStart,
  input  logic               byteValid,
  input  logic [IDX_IN_W-1:0] byteIdx,
  input  logic [7:0]         byteData,
  input  logic [PER_W-1:0]   clkPeriodTenths,
  output logic               infoValid,
  output logic               csumErr,
  output logic               isSdram,
  output logic [7:0]         casUsable,
  output logic [7:0]         rowBits,
  output logic [7:0]         colBits,
  output logic [2:0]         bankBits,
  output logic [CNT_W-1:0]   tRpClk,
  output logic [CNT_W-1:0]   tRcdClk,
  output logic [CNT_W-1:0]   tRasClk,
  output logic [CNT_W-1:0]   tRrdClk
);
  dp_strobe_t strobes;
  logic allSeen, sumMatch, divFinished;
  logic [NUM_TIMINGS-1:0][CNT_W-1:0] timingClk;

  spd_control u_ctrl (
    .clk(clk), .rstN(rstN), .imageStart(imageStart),
    .allSeen(allSeen), .sumMatch(sumMatch), .divFinished(divFinished),
    .strobes(strobes), .infoValid(infoValid), .csumErr(csumErr)
  );

  spd_datapath #(
    .IMG_BYTES(IMG_BYTES), .IDX_IN_W(IDX_IN_W), .PER_W(PER_W), .CNT_W(CNT_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .byteValid(byteValid), .byteIdx(byteIdx), .byteData(byteData),
    .clkPeriodTenths(clkPeriodTenths),
    .allSeen(allSeen), .sumMatch(sumMatch), .divFinished(divFinished),
    .isSdram(isSdram), .casUsable(casUsable), .rowBits(rowBits),
    .colBits(colBits), .bankBits(bankBits), .timingClk(timingClk)
  );

  // Divider slots follow byte order 27..30
  assign tRpClk  = timingClk[0];
  assign tRrdClk = timingClk[1];
  assign tRcdClk = timingClk[2];
  assign tRasClk = timingClk[3];
endmodule

// File: tb/test_spd_timing_decoder.sv
module test_spd_timing_decoder;
  logic        clk = 0;
  logic        rstN = 0;
  logic        imageStart = 0;
  logic        byteValid = 0;
  logic [7:0]  byteIdx = 0;
  logic [7:0]  byteData = 0;
  logic [7:0]  clkPeriodTenths = 8'd100;
  logic        infoValid, csumErr, isSdram;
  logic [7:0]  casUsable, rowBits, colBits;
  logic [2:0]  bankBits;
  logic [11:0] tRpClk, tRcdClk, tRasClk, tRrdClk;

  int nChecks = 0;
  int nErrors = 0;
  bit finished = 0;
  logic [7:0] img [64];
  logic [7:0] mMem [64];
  bit         mSeen [64];

  always #2.5 clk = ~clk;

  spd_timing_decoder i_spd_timing_decoder (
    .clk(clk), .rstN(rstN), .imageStart(imageStart), .byteValid(byteValid),
    .byteIdx(byteIdx), .byteData(byteData), .clkPeriodTenths(clkPeriodTenths),
    .infoValid(infoValid), .csumErr(csumErr), .isSdram(isSdram),
    .casUsable(casUsable), .rowBits(rowBits), .colBits(colBits),
    .bankBits(bankBits), .tRpClk(tRpClk), .tRcdClk(tRcdClk),
    .tRasClk(tRasClk), .tRrdClk(tRrdClk)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int expCnt(input int ns, input int p);
    if (ns == 0) return 0;
    return (ns * 10 + p - 1) / p;
  endfunction

  function automatic int expBank(input int b);
    for (int i = 0; i < 8; i++) if (b == (1 << i)) return i;
    return 0;
  endfunction

  function automatic int expCas(input int map, input int t0, input int t1, input int t2, input int p);
    int times[$];
    int res = 0;
    times = '{t0, t1, t2};
    for (int lat = 8; lat >= 1; lat--) begin
      if (map & (1 << (lat - 1))) begin
        if (times.size() > 0) begin
          int t = times.pop_front();
          if (t != 0 && ((t / 16) * 10 + (t % 16)) <= p) res |= (1 << (lat - 1));
        end
      end
    end
    return res;
  endfunction

  // Reference store of first-arrival bytes
  always @(posedge clk) begin
    if (!rstN || imageStart) begin
      for (int i = 0; i < 64; i++) begin mMem[i] <= 0; mSeen[i] <= 0; end
    end else if (byteValid && byteIdx < 64 && !mSeen[byteIdx]) begin
      mMem[byteIdx]  <= byteData;
      mSeen[byteIdx] <= 1;
    end
  end

  // Per-clock compare of decoded static fields (R2, R7)
  always begin
    @(negedge clk);
    #1;
    if (rstN && !finished) begin
      check(rowBits == mMem[3], "R2 rowBits", rowBits, mMem[3]);
      check(colBits == mMem[4], "R2 colBits", colBits, mMem[4]);
      check(isSdram == (mMem[2] == 8'h04), "R2 isSdram", isSdram, mMem[2] == 8'h04);
      check(bankBits == expBank(mMem[17]), "R2 bankBits", bankBits, expBank(mMem[17]));
      check(casUsable == expCas(mMem[18], mMem[9], mMem[23], mMem[25], clkPeriodTenths),
            "R7 casUsable", casUsable,
            expCas(mMem[18], mMem[9], mMem[23], mMem[25], clkPeriodTenths));
    end
  end

  task automatic baseImage();
    for (int i = 0; i < 64; i++) img[i] = 8'h00;
    img[0] = 8'h80; img[1] = 8'h08; img[2] = 8'h04; img[3] = 8'h0C;
    img[4] = 8'h08; img[5] = 8'h01; img[6] = 8'h40; img[8] = 8'h01;
    img[9] = 8'hA0; img[10] = 8'h60; img[12] = 8'h80; img[13] = 8'h10;
    img[16] = 8'h8F; img[17] = 8'h04; img[18] = 8'h06; img[19] = 8'h01;
    img[20] = 8'h01; img[22] = 8'h0E; img[23] = 8'hA0; img[24] = 8'h60;
    img[27] = 8'h14; img[28] = 8'h14; img[29] = 8'h14; img[30] = 8'h32;
    img[31] = 8'h08; img[32] = 8'h20; img[33] = 8'h10; img[34] = 8'h20;
    img[35] = 8'h10; img[62] = 8'h12;
  endtask

  task automatic fixSum();
    logic [7:0] s = 0;
    for (int i = 0; i < 63; i++) s += img[i];
    img[63] = s;
  endtask

  task automatic pulseStart();
    imageStart = 1; @(negedge clk); imageStart = 0;
  endtask

  task automatic sendByte(input int idx, input logic [7:0] val);
    byteValid = 1; byteIdx = 8'(idx); byteData = val;
    @(negedge clk);
    byteValid = 0;
  endtask

  task automatic sendImage(input bit reverse, input int skip);
    for (int k = 0; k < 64; k++) begin
      int idx = reverse ? 63 - k : k;
      if (idx != skip) sendByte(idx, img[idx]);
    end
  endtask

  task automatic waitOutcome();
    for (int c = 0; c < 5000; c++) begin
      if (infoValid || csumErr) break;
      @(negedge clk);
    end
  endtask

  task automatic checkTimings(input string tag);
    int p = clkPeriodTenths;
    check(tRpClk == expCnt(img[27], p), {tag, " tRp"}, tRpClk, expCnt(img[27], p));
    check(tRrdClk == expCnt(img[28], p), {tag, " tRrd"}, tRrdClk, expCnt(img[28], p));
    check(tRcdClk == expCnt(img[29], p), {tag, " tRcd"}, tRcdClk, expCnt(img[29], p));
    check(tRasClk == expCnt(img[30], p), {tag, " tRas"}, tRasClk, expCnt(img[30], p));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!infoValid && !csumErr, "R1 flags", infoValid + 2 * csumErr, 0);
    check(tRpClk == 0 && tRasClk == 0 && tRcdClk == 0 && tRrdClk == 0, "R1 counts", tRasClk, 0);
    check(casUsable == 0 && rowBits == 0 && bankBits == 0, "R1 fields", casUsable, 0);
    rstN = 1;
    @(negedge clk);

    // R5/R6: ascending order, exact division at 10 ns
    baseImage(); fixSum();
    clkPeriodTenths = 8'd100;
    pulseStart();
    sendImage(0, -1);
    waitOutcome();
    check(infoValid && !csumErr, "R5 valid after good image", infoValid, 1);
    checkTimings("R6 p100");
    check(casUsable == 8'h06, "R7 both latencies at 10ns", casUsable, 8'h06);
    repeat (10) @(negedge clk);
    check(infoValid, "R5 valid holds", infoValid, 1);

    // R9: clear
    pulseStart();
    check(!infoValid && !csumErr, "R9 flags cleared", infoValid, 0);
    check(tRpClk == 0 && tRasClk == 0, "R9 counts cleared", tRasClk, 0);
    check(rowBits == 0, "R9 bytes cleared", rowBits, 0);

    // R8/R6: descending order, ceiling at 7.5 ns
    clkPeriodTenths = 8'd75;
    sendImage(1, -1);
    waitOutcome();
    check(infoValid, "R8 valid in reverse order", infoValid, 1);
    checkTimings("R8 R6 p75");
    check(tRasClk == 7 && tRpClk == 3, "R6 ceiling rounding", tRasClk, 7);
    check(casUsable == 8'h00, "R7 no latency at 7.5ns", casUsable, 0);

    // R7: slower second cycle time
    baseImage(); img[23] = 8'hC0; img[30] = 8'h30; img[28] = 8'h10; fixSum();
    clkPeriodTenths = 8'd100;
    pulseStart();
    sendImage(0, -1);
    waitOutcome();
    check(casUsable == 8'h04, "R7 only highest latency", casUsable, 8'h04);
    checkTimings("R6 variant");

    // R2: first copy of an index wins
    baseImage(); fixSum();
    pulseStart();
    sendByte(27, img[27]);
    sendByte(27, 8'h50);
    sendImage(0, 27);
    waitOutcome();
    check(infoValid && !csumErr, "R2 duplicate ignored in sum", infoValid, 1);
    check(tRpClk == 2, "R2 duplicate ignored in value", tRpClk, 2);

    // R3: high indices ignored while one byte is missing
    pulseStart();
    sendImage(0, 5);
    sendByte(69, 8'h33);
    sendByte(200, 8'h04);
    repeat (20) @(negedge clk);
    check(!infoValid && !csumErr, "R3 high index does not complete", infoValid + csumErr, 0);
    sendByte(5, img[5]);
    waitOutcome();
    check(infoValid && !csumErr, "R3 high index leaves sum intact", csumErr, 0);

    // R4: corrupted byte
    img[40] = img[40] + 8'd1;
    pulseStart();
    sendImage(0, -1);
    waitOutcome();
    repeat (3) @(negedge clk);
    check(csumErr, "R4 error flag", csumErr, 1);
    check(!infoValid, "R4 no valid", infoValid, 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      finished = 1;
      nChecks++; nErrors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
      $finish;
    end
  end
endmodule